// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Target

This block is a target on a two-wire serial bus. It holds a 2048-entry array of 8-bit words. A bus controller reaches any word through an 11-bit address. Each transfer begins with a device byte. Its upper four bits carry the fixed type code `1010`, bits 3..1 carry address bits 10..8 (the page), and bit 0 selects read (1) or write (0). A write transfer then sends the low eight address bits, followed by any number of data bytes. Each data byte is committed to the array as soon as its eighth bit arrives, so the target never has a busy period and acknowledges the next transfer at once.

Reads start at the internal pointer. A random read is a write transfer that carries only the address, then a repeated start and a read device byte. A current-address read needs only the read device byte. The pointer moves forward by one after every byte read or written, and it wraps from 2047 to 0. While the write-protect input is high, data bytes are still acknowledged, but they are thrown away. Reads are never blocked by write protect. The write-protect synchroniser resets low, so the target comes out of reset with writes enabled.

SCL and SDA are sampled by a fast system clock. Each passes through a two-flop synchroniser, and rising and falling edges are detected after it. SDA is open drain. The target has a single output that pulls the line low, and it never drives the line high.

The controller state machine uses these states:
- `ST_IDLE`: waits for a start condition.
- `ST_DEV`: shifts in the device byte.
- `ST_DEV_ACK`: acknowledges the device byte.
- `ST_WADDR`: shifts in the word address.
- `ST_WADDR_ACK`: acknowledges the word address.
- `ST_WDATA`: shifts in a data byte.
- `ST_WDATA_ACK`: acknowledges a data byte.
- `ST_RBITS`: shifts a data byte out.
- `ST_RACK`: samples the controller's acknowledge.

The transitions are:
- Start, from any state, goes to `ST_DEV`.
- Stop, from any state, goes to `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` when the type code matches, and to `ST_IDLE` when it does not.
- `ST_DEV_ACK` goes to `ST_WADDR` for a write, or to `ST_RBITS` for a read.
- `ST_WADDR` goes to `ST_WADDR_ACK`, and `ST_WADDR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, and `ST_WDATA_ACK` goes back to `ST_WDATA`.
- `ST_RBITS` goes to `ST_RACK`.
- `ST_RACK` goes to `ST_RBITS` when the controller acknowledges, and to `ST_IDLE` when it does not.

Top module: `twi_byte_mem`

## Requirements
- R1: A device byte whose bits 7..4 equal `1010` is acknowledged: SDA is held low through the ninth SCL pulse. Any other code gets no acknowledge, and the target ignores the bus until the next start.
- R2: A write of device byte, word address and data, followed by a random read, returns the written byte. Address bits 10..8 come from device-byte bits 3..1, and address bits 7..0 come from the word-address byte.
- R3: The pointer advances by one after every byte written or read, and it wraps from 2047 to 0.
- R4: While write protect is high, data bytes are acknowledged and the array is left unchanged.
- R5: Reads return stored data while write protect is high.
- R6: A device byte sent straight after the stop that ends a write is acknowledged. The target has no busy interval.
- R7: A start or stop condition in the middle of a byte abandons that byte. A partly received data byte is never written, and a new device byte after a repeated start is framed from its first bit.
- R8: After the controller answers a read byte with an acknowledge (SDA low), the next byte follows. After no acknowledge, the target releases SDA and stays released until the next start.
- R9: A read device byte with no address phase returns the byte at the current pointer.
- R10: SDA is captured on SCL rising edges. The pull-low output changes only while SCL is low, it is the only drive the target has, and it is released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sensed level of the serial data line |
| wp_i | input | 1 | Write protect; high discards write data |
| sda_low_o | output | 1 | High pulls SDA low; low releases the line |

## Verification
A wrong state or bit count moves the acknowledge slot or shifts read data by one position. Either fault shows up within the same byte, as a missing acknowledge or a corrupted byte at the controller. A pointer fault is only seen on the next read, which returns a neighbouring or stale word. This is why the tests write several bytes before reading them back across the 2047-to-0 wrap. Write-protect and framing faults only show as changed contents, so every write-protected or aborted write is followed by a read-back of the same address.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RBITS,
        ST_RACK
    } twi_state_e;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int             N       = 2,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign lvl_o = chain_q[STAGES-1];

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] =  chain_q[STAGES-1][i] & ~prev_q[i];
        assign fall_o[i] = ~chain_q[STAGES-1][i] &  prev_q[i];
    end

endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i && !wp_i) cells[addr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= cells[addr_i];
    end

endmodule

// File: rtl/twi_fsm.sv
module twi_fsm
    import twi_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int DEV_CODE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              sda_low_o
);

    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam int CODE_W = DATA_W - 1 - PAGE_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CODE_W-1:0] CODE_V   = CODE_W'(DEV_CODE);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0]  ALL_BITS = CNT_W'(DATA_W);

    twi_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic [PAGE_W-1:0] page_q, page_n;
    logic [ADDR_W-1:0] ptr_q, ptr_n;
    logic              ack_q, ack_n;
    logic              rdf_q, rdf_n;
    logic              mack_q, mack_n;
    logic              drv_q, drv_n;
    logic              we_q, we_n;
    logic [DATA_W-1:0] wd_q, wd_n;
    logic [DATA_W-1:0] byte_v;

    assign byte_v = {sh_q[DATA_W-2:0], sda_s};

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        page_n  = page_q;
        ptr_n   = ptr_q;
        ack_n   = ack_q;
        rdf_n   = rdf_q;
        mack_n  = mack_q;
        drv_n   = drv_q;
        we_n    = 1'b0;
        wd_n    = wd_q;

        if (we_q) ptr_n = ptr_q + 1'b1;

        if (start_evt) begin
            state_n = ST_DEV;
            cnt_n   = '0;
            drv_n   = 1'b0;
            ack_n   = 1'b0;
        end else if (stop_evt) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            drv_n   = 1'b0;
            ack_n   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    drv_n = 1'b0;
                end
                ST_DEV: begin
                    if (scl_rise) begin
                        sh_n  = byte_v;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            cnt_n = '0;
                            if (byte_v[DATA_W-1 -: CODE_W] == CODE_V) begin
                                rdf_n   = byte_v[0];
                                if (!byte_v[0]) page_n = byte_v[PAGE_W:1];
                                state_n = ST_DEV_ACK;
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_rise) begin
                        sh_n  = byte_v;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            cnt_n   = '0;
                            ptr_n   = {page_q, byte_v};
                            state_n = ST_WADDR_ACK;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh_n  = byte_v;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            cnt_n   = '0;
                            we_n    = 1'b1;
                            wd_n    = byte_v;
                            state_n = ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!ack_q) begin
                            drv_n = 1'b1;
                            ack_n = 1'b1;
                        end else begin
                            drv_n = 1'b0;
                            ack_n = 1'b0;
                            cnt_n = '0;
                            if (state_q == ST_DEV_ACK && rdf_q) begin
                                sh_n    = rd_data_i;
                                drv_n   = !rd_data_i[DATA_W-1];
                                ptr_n   = ptr_q + 1'b1;
                                state_n = ST_RBITS;
                            end else if (state_q == ST_DEV_ACK) begin
                                state_n = ST_WADDR;
                            end else begin
                                state_n = ST_WDATA;
                            end
                        end
                    end
                end
                ST_RBITS: begin
                    if (scl_rise) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == ALL_BITS) begin
                            drv_n   = 1'b0;
                            state_n = ST_RACK;
                        end else begin
                            sh_n  = {sh_q[DATA_W-2:0], sh_q[DATA_W-1]};
                            drv_n = !sh_q[DATA_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_n = !sda_s;
                    end else if (scl_fall) begin
                        cnt_n = '0;
                        if (mack_q) begin
                            sh_n    = rd_data_i;
                            drv_n   = !rd_data_i[DATA_W-1];
                            ptr_n   = ptr_q + 1'b1;
                            state_n = ST_RBITS;
                        end else begin
                            drv_n   = 1'b0;
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    drv_n   = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            page_q <= '0;
            ptr_q  <= '0;
            ack_q  <= 1'b0;
            rdf_q  <= 1'b0;
            mack_q <= 1'b0;
            drv_q  <= 1'b0;
            we_q   <= 1'b0;
            wd_q   <= '0;
        end else begin
            cnt_q  <= cnt_n;
            sh_q   <= sh_n;
            page_q <= page_n;
            ptr_q  <= ptr_n;
            ack_q  <= ack_n;
            rdf_q  <= rdf_n;
            mack_q <= mack_n;
            drv_q  <= drv_n;
            we_q   <= we_n;
            wd_q   <= wd_n;
        end
    end

    assign mem_addr_o  = ptr_q;
    assign mem_wdata_o = wd_q;
    assign mem_we_o    = we_q;
    assign sda_low_o   = drv_q;

    // R10: the pull-low output may only move while SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_q != $past(drv_q)) |-> !scl_s);

    // R7: a start always restarts byte framing
    a_r7_start_frames: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state_q == ST_DEV && cnt_q == '0));

    // R8: no acknowledge from the controller releases the line
    a_r8_release_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK && scl_fall && !mack_q && !start_evt && !stop_evt)
        |=> (state_q == ST_IDLE && !drv_q));

    // R1: the line is pulled only in acknowledge or read-out states
    a_r1_drive_owed: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q |-> (state_q inside {ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RBITS}));

    // R3: inside a data phase the pointer moves only by one step
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {ST_WDATA, ST_WDATA_ACK, ST_RBITS, ST_RACK}) &&
         ($past(state_q) inside {ST_WDATA, ST_WDATA_ACK, ST_RBITS, ST_RACK}) &&
         ptr_q != $past(ptr_q))
        |-> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

endmodule

// File: rtl/twi_byte_mem.sv
module twi_byte_mem #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int DEV_CODE = 10,
    parameter int SYNC_N   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_low_o
);

    logic [1:0] bus_lvl, bus_rise, bus_fall;
    logic [SYNC_N-1:0] wp_q;
    logic scl_s, sda_s, start_evt, stop_evt;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic mem_we;

    twi_sync #(.N(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({scl_i, sda_i}),
        .lvl_o  (bus_lvl),
        .rise_o (bus_rise),
        .fall_o (bus_fall)
    );

    // write protect resets low so writes are enabled until it is driven
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= {wp_q[SYNC_N-2:0], wp_i};
    end

    assign scl_s     = bus_lvl[1];
    assign sda_s     = bus_lvl[0];
    assign start_evt = scl_s && !bus_rise[1] && bus_fall[0];
    assign stop_evt  = scl_s && !bus_rise[1] && bus_rise[0];

    twi_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_CODE(DEV_CODE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .scl_rise    (bus_rise[1]),
        .scl_fall    (bus_fall[1]),
        .sda_s       (sda_s),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .rd_data_i   (mem_rdata),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .sda_low_o   (sda_low_o)
    );

    twi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .wp_i    (wp_q[SYNC_N-1]),
        .addr_i  (mem_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

endmodule

// File: tb/sim_twi_byte_mem.sv
`timescale 1ns/1ps
module sim_twi_byte_mem;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_low;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_low;

    always #2.5 clk = ~clk;

    twi_byte_mem u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .wp_i      (wp),
        .sda_low_o (sda_low)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } sb_item_t;

    sb_item_t   exp_q[$];
    logic [7:0] obs_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input string tag);
        sb_item_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                sb_item_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(o, e.val, e.tag);
            end
        end
    endtask_dummy_guard: begin end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic mbit_w(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic mbit_r(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    function automatic logic [7:0] devb(input logic [3:0] code, input logic [2:0] pg, input logic rd);
        return {code, pg, rd};
    endfunction

    task automatic tx(input logic [7:0] v, input logic exp_ack, input string tag);
        logic a;
        for (int i = 7; i >= 0; i--) mbit_w(v[i]);
        mbit_r(a);
        push_exp(8'(exp_ack), tag);
        obs_q.push_back(8'(!a));
    endtask

    task automatic rx(input logic [7:0] expv, input logic mack, input string tag);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) mbit_r(v[i]);
        mbit_w(!mack);
        push_exp(expv, tag);
        obs_q.push_back(v);
    endtask

    task automatic rand_read_start(input logic [10:0] a, input string tag);
        bus_start();
        tx(devb(4'hA, a[10:8], 1'b0), 1'b1, tag);
        tx(a[7:0], 1'b1, tag);
        bus_start();
        tx(devb(4'hA, a[10:8], 1'b1), 1'b1, tag);
    endtask

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(8'(sda_low), 8'h00, "R10 line released after reset");

        // R2 write with page bits, then R6 immediate next transfer
        bus_start();
        tx(devb(4'hA, 3'h5, 1'b0), 1'b1, "R1 device byte ack");
        tx(8'hAB, 1'b1, "R2 word address ack");
        tx(8'h3C, 1'b1, "R2 data ack");
        tx(8'h4D, 1'b1, "R3 second data ack");
        bus_stop();
        bus_start();
        tx(devb(4'hA, 3'h5, 1'b0), 1'b1, "R6 no busy after write");
        tx(8'hAB, 1'b1, "R6 address ack");
        bus_start();
        tx(devb(4'hA, 3'h5, 1'b1), 1'b1, "R2 read device ack");
        rx(8'h3C, 1'b0, "R2 random read 0x5AB");
        bus_stop();

        // R3 wrap at top of array
        bus_start();
        tx(devb(4'hA, 3'h7, 1'b0), 1'b1, "R3 dev");
        tx(8'hFF, 1'b1, "R3 addr");
        tx(8'hA1, 1'b1, "R3 data 7FF");
        tx(8'hB2, 1'b1, "R3 data wraps to 000");
        tx(8'hC3, 1'b1, "R3 data 001");
        bus_stop();
        rand_read_start(11'h7FF, "R3 read setup");
        rx(8'hA1, 1'b1, "R3 read 7FF");
        rx(8'hB2, 1'b0, "R3 read wrapped 000");
        bus_stop();

        // R9 current address read continues at 001
        bus_start();
        tx(devb(4'hA, 3'h0, 1'b1), 1'b1, "R9 current read dev");
        rx(8'hC3, 1'b0, "R9 current address byte");
        bus_stop();

        // R8 sequential read with ack, then nack releases line
        rand_read_start(11'h5AB, "R8 setup");
        rx(8'h3C, 1'b1, "R8 first byte");
        rx(8'h4D, 1'b0, "R8 byte after ack");
        mbit_r(b);
        chk(8'(b), 8'h01, "R8 released after nack");
        bus_stop();

        // R4 / R5 write protect
        bus_start();
        tx(devb(4'hA, 3'h1, 1'b0), 1'b1, "R4 setup dev");
        tx(8'h23, 1'b1, "R4 setup addr");
        tx(8'h55, 1'b1, "R4 setup data");
        bus_stop();
        wp = 1'b1;
        bus_start();
        tx(devb(4'hA, 3'h1, 1'b0), 1'b1, "R4 protected dev ack");
        tx(8'h23, 1'b1, "R4 protected addr ack");
        tx(8'h77, 1'b1, "R4 protected data still acked");
        bus_stop();
        rand_read_start(11'h123, "R5 setup");
        rx(8'h55, 1'b0, "R4 protected byte unchanged");
        bus_stop();
        rand_read_start(11'h5AB, "R5 read under protect");
        rx(8'h3C, 1'b0, "R5 read allowed with protect high");
        bus_stop();
        wp = 1'b0;

        // R1 wrong type code is ignored
        bus_start();
        tx(devb(4'hB, 3'h1, 1'b0), 1'b0, "R1 wrong code not acked");
        tx(8'h23, 1'b0, "R1 ignored after wrong code");
        tx(8'h99, 1'b0, "R1 ignored data");
        bus_stop();
        rand_read_start(11'h123, "R1 check setup");
        rx(8'h55, 1'b0, "R1 array untouched by wrong code");
        bus_stop();

        // R7 aborted bytes
        bus_start();
        tx(devb(4'hA, 3'h0, 1'b0), 1'b1, "R7 setup dev");
        tx(8'h10, 1'b1, "R7 setup addr");
        tx(8'h11, 1'b1, "R7 setup data");
        bus_stop();
        bus_start();
        tx(devb(4'hA, 3'h0, 1'b0), 1'b1, "R7 dev");
        tx(8'h10, 1'b1, "R7 addr");
        for (int i = 0; i < 4; i++) mbit_w(1'b1);
        bus_stop();
        bus_start();
        tx(devb(4'hA, 3'h0, 1'b0), 1'b1, "R7 dev again");
        for (int i = 0; i < 5; i++) mbit_w(1'b0);
        bus_start();
        tx(devb(4'hA, 3'h0, 1'b0), 1'b1, "R7 reframed after repeated start");
        tx(8'h10, 1'b1, "R7 addr after restart");
        bus_start();
        tx(devb(4'hA, 3'h0, 1'b1), 1'b1, "R7 read dev");
        rx(8'h11, 1'b0, "R7 partial byte not written");
        bus_stop();
        repeat (10) @(negedge clk);
        chk(8'(sda_low), 8'h00, "R10 released when idle");

        repeat (20) @(negedge clk);
        chk(8'(exp_q.size()), 8'(obs_q.size()), "scoreboard drained");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule